// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps, for each of a small number of CPUs, one pending bit for inter-processor interrupts (IPIs) and one pending bit for the periodic timer interrupt. Each pending bit drives that CPU's interrupt line for its class directly. Software works on the pending bits through a register port. A combined control register can post IPIs, clear IPIs and clear timer interrupts in a single write. Three single-purpose registers each do one of those operations, and each takes the written value as a CPU mask.

A timer tick input marks the timer interrupt pending on every CPU. The block also reports misuse on three one-cycle flags. One flag marks a write that carries no command. One marks a post to a CPU whose IPI is already pending. One marks an IPI clear aimed at a CPU with nothing pending. Reads return the pending state and, for the control register, the ID of the reading CPU.

Top module: `irq_ipi_timer_ctl`

## Requirements
- R1: After reset, every pending bit, both interrupt vectors, all three flags and the read data are zero.
- R2: A write to the control register (select 0) sets the IPI pending bit of CPU i for every set bit 12+i of the write data. The matching `ipi_irq` bit is high from the clock edge that takes the write.
- R3: In a control write, bit 8+i clears the IPI of CPU i and bit 4+i clears the timer interrupt of CPU i. If one write both posts and clears the IPI of the same CPU, the clear is applied after the post, so that CPU's IPI ends up cleared.
- R4: A control write whose only set bit is bit 28 is accepted. It raises no flag and changes no pending bit.
- R5: A control write with bits 15:4 all zero and bit 28 zero raises `err_illegal` for one cycle and changes no pending bit.
- R6: Posting an IPI to a CPU whose IPI is already pending leaves that bit set and raises `warn_dup_post` for one cycle.
- R7: Clearing the IPI of a CPU that is not pending, and is not posted by the same write, changes nothing for that CPU and raises `warn_empty_clear` for one cycle.
- R8: A `tick` cycle sets the timer pending bit of every CPU. If a timer clear hits the same CPU in the same cycle, the tick wins and the bit stays set.
- R9: A timer clear affects only CPUs that are both selected and pending. Without a tick, no timer bit ever rises. Clearing a timer bit that is not pending raises no flag.
- R10: A write to select 1 posts IPIs, a write to select 2 clears IPIs, and a write to select 3 clears timer interrupts. Each uses write data bits NCPU-1:0 as the CPU mask, and R6 and R7 apply to these writes as well.
- R11: A write to select 1, 2 or 3 whose mask bits NCPU-1:0 are all zero raises `err_illegal` for one cycle and changes no pending bit.
- R12: A read registers `rdata` at the clock edge that takes it. Select 0 returns IPI pending in bits 11:8, timer pending in bits 7:4 and `cpu_id` in bits 1:0. Select 2 returns IPI pending in the low bits, select 3 returns timer pending in the low bits, and select 1 returns zero. All other bits are zero.
- R13: The flags are low in every cycle that does not follow a write, and the IPI vector changes only after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 2 | Register select: 0 control, 1 IPI request, 2 IPI pending, 3 timer pending |
| wdata | input | DATA_W | Write data |
| cpu_id | input | ID_W | ID of the CPU making the access |
| tick | input | 1 | Timer tick, posts a timer interrupt to all CPUs |
| rdata | output | DATA_W | Registered read data |
| ipi_irq | output | NCPU | Per-CPU IPI lines |
| tmr_irq | output | NCPU | Per-CPU timer interrupt lines |
| err_illegal | output | 1 | Pulse: the write carried no command |
| warn_dup_post | output | 1 | Pulse: an IPI was posted to a CPU that already had one pending |
| warn_empty_clear | output | 1 | Pulse: an IPI clear hit a CPU with no IPI pending |

## Verification
Several properties are checked on every cycle. Posted IPI bits rise after a control write that carries no clear. Every tick fills the timer vector. Timer bits never rise without a tick. Empty writes, including zero-mask writes to the single-purpose registers, always raise the error flag. The IPI vector and the flags stay quiet when there is no write. The exact post-then-clear ordering and the exact warning conditions come only from the bench's sweeps. The bench sweeps every starting state against every post and clear mask, runs the tick-versus-clear collision, and checks read-back of the ID field.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'd0,
    SEL_IPI_REQ  = 2'd1,
    SEL_IPI_PEND = 2'd2,
    SEL_TMR_PEND = 2'd3
  } reg_sel_e;

  // control register field positions (each field is one bit per CPU)
  localparam int POST_LSB = 12;
  localparam int ICLR_LSB = 8;
  localparam int TCLR_LSB = 4;
  localparam int NXM_BIT  = 28;
  // read-back positions in the control register
  localparam int RD_IPI_LSB = 8;
  localparam int RD_TMR_LSB = 4;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_ctl_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int DATA_W = 64
) (
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCPU-1:0]   ipi_set,
  output logic [NCPU-1:0]   ipi_clr,
  output logic [NCPU-1:0]   tmr_clr,
  output logic              illegal
);
  logic [NCPU-1:0] f_post, f_iclr, f_tclr, f_mask;

  assign f_post = wdata[POST_LSB +: NCPU];
  assign f_iclr = wdata[ICLR_LSB +: NCPU];
  assign f_tclr = wdata[TCLR_LSB +: NCPU];
  assign f_mask = wdata[NCPU-1:0];

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    illegal = 1'b0;
    if (wr_en) begin
      unique case (reg_sel_e'(sel))
        SEL_CTRL: begin
          ipi_set = f_post;
          ipi_clr = f_iclr;
          tmr_clr = f_tclr;
          illegal = (f_post == '0) && (f_iclr == '0) && (f_tclr == '0) && !wdata[NXM_BIT];
        end
        SEL_IPI_REQ: begin
          ipi_set = f_mask;
          illegal = (f_mask == '0);
        end
        SEL_IPI_PEND: begin
          ipi_clr = f_mask;
          illegal = (f_mask == '0);
        end
        default: begin
          tmr_clr = f_mask;
          illegal = (f_mask == '0);
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_pend_vec.sv
module irq_pend_vec #(
  parameter int NCPU     = 4,
  parameter bit SET_WINS = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCPU-1:0] set_mask,
  input  logic [NCPU-1:0] clr_mask,
  output logic [NCPU-1:0] pend
);
  logic [NCPU-1:0] nxt;

  generate
    if (SET_WINS) begin : g_set_wins
      assign nxt = (pend & ~clr_mask) | set_mask;
    end else begin : g_clr_wins
      assign nxt = (pend | set_mask) & ~clr_mask;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= nxt;
  end
endmodule

// File: rtl/irq_ipi_timer_ctl.sv
module irq_ipi_timer_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int DATA_W = 64,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ID_W-1:0]   cpu_id,
  input  logic              tick,
  output logic [DATA_W-1:0] rdata,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq,
  output logic              err_illegal,
  output logic              warn_dup_post,
  output logic              warn_empty_clear
);
  logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr;
  logic            illegal;
  logic [NCPU-1:0] ipi_pend, tmr_pend;
  logic [DATA_W-1:0] rd_nxt;

  irq_cmd_decode #(.NCPU(NCPU), .DATA_W(DATA_W)) u_dec (
    .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .ipi_set(ipi_set), .ipi_clr(ipi_clr), .tmr_clr(tmr_clr), .illegal(illegal)
  );

  // IPI: post then clear inside one write, so clear wins
  irq_pend_vec #(.NCPU(NCPU), .SET_WINS(1'b0)) u_ipi (
    .clk(clk), .rst(rst), .set_mask(ipi_set), .clr_mask(ipi_clr), .pend(ipi_pend)
  );

  // timer: tick beats a same-cycle clear
  irq_pend_vec #(.NCPU(NCPU), .SET_WINS(1'b1)) u_tmr (
    .clk(clk), .rst(rst), .set_mask({NCPU{tick}}), .clr_mask(tmr_clr), .pend(tmr_pend)
  );

  assign ipi_irq = ipi_pend;
  assign tmr_irq = tmr_pend;

  always_comb begin
    rd_nxt = '0;
    unique case (reg_sel_e'(sel))
      SEL_CTRL: begin
        rd_nxt[RD_IPI_LSB +: NCPU] = ipi_pend;
        rd_nxt[RD_TMR_LSB +: NCPU] = tmr_pend;
        rd_nxt[ID_W-1:0]           = cpu_id;
      end
      SEL_IPI_PEND: rd_nxt[NCPU-1:0] = ipi_pend;
      SEL_TMR_PEND: rd_nxt[NCPU-1:0] = tmr_pend;
      default:      rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata            <= '0;
      err_illegal      <= 1'b0;
      warn_dup_post    <= 1'b0;
      warn_empty_clear <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_nxt;
      err_illegal      <= illegal;
      warn_dup_post    <= |(ipi_set & ipi_pend);
      warn_empty_clear <= |(ipi_clr & ~(ipi_pend | ipi_set));
    end
  end
endmodule

// File: rtl/irq_ctl_checker.sv
module irq_ctl_checker
  import irq_ctl_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        sel,
  input logic [DATA_W-1:0] wdata,
  input logic              tick,
  input logic [NCPU-1:0]   ipi_irq,
  input logic [NCPU-1:0]   tmr_irq,
  input logic              err_illegal,
  input logic              warn_dup_post,
  input logic              warn_empty_clear
);
  logic ctrl_wr, empty_ctrl;
  assign ctrl_wr    = wr_en && (sel == 2'd0);
  assign empty_ctrl = ctrl_wr && (wdata[POST_LSB +: NCPU] == '0) && (wdata[ICLR_LSB +: NCPU] == '0)
                      && (wdata[TCLR_LSB +: NCPU] == '0) && !wdata[NXM_BIT];

  AST_POST_RISES: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && (wdata[ICLR_LSB +: NCPU] == '0)
    |=> ((ipi_irq & $past(wdata[POST_LSB +: NCPU])) == $past(wdata[POST_LSB +: NCPU]))); // R2
  AST_EMPTY_CTRL_ERR: assert property (@(posedge clk) disable iff (rst)
    empty_ctrl && !tick |=> err_illegal && $stable(ipi_irq) && $stable(tmr_irq)); // R5
  AST_TICK_FILLS: assert property (@(posedge clk) disable iff (rst)
    tick |=> (&tmr_irq)); // R8
  AST_TMR_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ((tmr_irq & ~$past(tmr_irq)) == '0)); // R9
  AST_ZERO_MASK_ERR: assert property (@(posedge clk) disable iff (rst)
    wr_en && (sel != 2'd0) && (wdata[NCPU-1:0] == '0) |=> err_illegal); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ipi_irq) && !err_illegal && !warn_dup_post && !warn_empty_clear); // R13
endmodule

bind irq_ipi_timer_ctl irq_ctl_checker #(.NCPU(NCPU), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata), .tick(tick),
  .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .err_illegal(err_illegal),
  .warn_dup_post(warn_dup_post), .warn_empty_clear(warn_empty_clear)
);

// File: tb/irq_ipi_timer_ctl_test.sv
`timescale 1ns/1ps
module irq_ipi_timer_ctl_test;
  localparam int NCPU = 4;
  localparam int DW   = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    cpu_id = 2'd0;
  logic [DW-1:0] rdata;
  logic [NCPU-1:0] ipi_irq, tmr_irq;
  logic err_illegal, warn_dup_post, warn_empty_clear;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_ipi_timer_ctl #(.NCPU(NCPU), .DATA_W(DW), .ID_W(2)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wdata(wdata),
    .cpu_id(cpu_id), .tick(tick), .rdata(rdata), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
    .err_illegal(err_illegal), .warn_dup_post(warn_dup_post), .warn_empty_clear(warn_empty_clear)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d, input logic tk);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d; tick = tk;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; wdata = '0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [1:0] id);
    @(negedge clk);
    rd_en = 1'b1; sel = s; cpu_id = id;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_ipi(input logic [3:0] s);
    wr(2'd2, 64'hF, 1'b0);
    if (s != 0) wr(2'd1, {60'd0, s}, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ipi", ipi_irq, 0);
    chk("R1 tmr", tmr_irq, 0);
    chk("R1 flags", {err_illegal, warn_dup_post, warn_empty_clear}, 0);
    chk("R1 rdata", rdata, 0);

    // IPI sweep through the control register: R2 R3 R5 R6 R7 R10
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        for (int c = 0; c < 16; c++) begin
          logic [3:0] es;
          set_ipi(s[3:0]);
          chk("R10 setup", ipi_irq, s[3:0]);
          wr(2'd0, (64'(p) << 12) | (64'(c) << 8), 1'b0);
          if (p == 0 && c == 0) begin
            chk("R5 err", err_illegal, 1);
            chk("R5 ipi held", ipi_irq, s[3:0]);
          end else begin
            es = (s[3:0] | p[3:0]) & ~c[3:0];
            chk("R2 R3 ipi", ipi_irq, es);
            chk("R5 no err", err_illegal, 0);
          end
          chk("R6 dup", warn_dup_post, |(s[3:0] & p[3:0]));
          chk("R7 empty", warn_empty_clear, |(c[3:0] & ~(s[3:0] | p[3:0])));
        end
      end
    end

    // R13 flags drop on an idle cycle after a flagged write
    set_ipi(4'h3);
    wr(2'd1, 64'h1, 1'b0);
    chk("R6 dedicated dup", warn_dup_post, 1);
    wr(2'd2, 64'h8, 1'b0);
    chk("R7 dedicated empty", warn_empty_clear, 1);
    chk("R10 ipi", ipi_irq, 4'h3);
    @(negedge clk);
    chk("R13 idle flags", {err_illegal, warn_dup_post, warn_empty_clear}, 0);

    // timer sweep: R3 R8 R9 R10
    for (int s = 0; s < 16; s++) begin
      for (int c = 1; c < 16; c++) begin
        for (int t = 0; t < 2; t++) begin
          logic [3:0] drop;
          pulse_tick();
          chk("R8 tick", tmr_irq, 4'hF);
          drop = ~s[3:0];
          if (drop != 0) wr(2'd3, {60'd0, drop}, 1'b0);
          chk("R10 tmr clear", tmr_irq, s[3:0]);
          wr(2'd0, 64'(c) << 4, t[0]);
          chk("R3 R8 R9 tmr", tmr_irq, t[0] ? 4'hF : (s[3:0] & ~c[3:0]));
          chk("R9 no flags", {err_illegal, warn_dup_post, warn_empty_clear}, 0);
        end
      end
    end

    // R4 non-existent-memory acknowledge only
    set_ipi(4'h5);
    wr(2'd3, 64'hA, 1'b0);
    wr(2'd0, 64'h1000_0000, 1'b0);
    chk("R4 err", err_illegal, 0);
    chk("R4 ipi", ipi_irq, 4'h5);
    chk("R4 tmr", tmr_irq, 4'h5);

    // R11 zero masks on dedicated registers
    for (int s = 1; s < 4; s++) begin
      wr(s[1:0], 64'hFFF0, 1'b0);
      chk("R11 err", err_illegal, 1);
      chk("R11 ipi", ipi_irq, 4'h5);
      chk("R11 tmr", tmr_irq, 4'h5);
    end

    // R12 read-back
    for (int id = 0; id < 4; id++) begin
      rd(2'd0, id[1:0]);
      chk("R12 ctrl", rdata, (64'h5 << 8) | (64'h5 << 4) | 64'(id));
    end
    wr(2'd1, 64'h2, 1'b0);
    rd(2'd2, 2'd3);
    chk("R12 ipi pend", rdata, 64'h7);
    rd(2'd3, 2'd3);
    chk("R12 tmr pend", rdata, 64'h5);
    rd(2'd1, 2'd3);
    chk("R12 req", rdata, 64'h0);

    finish_run();
  end
endmodule